// File: doc/BRIEF.md
# Multiplexed-Bus Byte RAM Slave

This block sits on the bus of an 8-bit processor with a 16-bit address space in which the low address byte and the data byte travel over the same eight lines. While the address strobe is high, the shared lines are taken as the low address byte. When the strobe falls, that byte is held. The held byte is joined with the separately driven high address byte to form the full address.

The six most significant address bits are compared against a fixed select pattern, which is a parameter. The default pattern places the block at 2000h to 23FFh. The remaining ten bits pick one of 1024 byte locations. Memory cycles are marked by a low level on the memory/IO line, and IO cycles never reach the storage.

Each byte location is stored as two 4-bit-wide arrays that share the same address decode, one for the low nibble and one for the high nibble. The shared data lines are modelled as three separate signals: a data input, a data output and an output enable. The output enable marks the cycles in which the block would drive the lines. Reads and writes use active-low strobes. The bus has no flow control: every strobe is served at once. Each input is sampled on the rising edge of the block clock, and the strobes must be held for at least one clock.

Top module: `mux_bus_ram`

## Requirements
- R1: The block responds only when address bits 15:10 equal the parameter SEL_PATTERN. With the default 6'b001000, this is exactly addresses 2000h through 23FFh. An access to any other address neither drives the bus nor changes storage.
- R2: When io_m is high (IO cycle), `bus_oe` stays low and write strobes leave storage unchanged, whatever the address is.
- R3: While `ale` is high, the low address byte follows `bus_din`. After `ale` falls, the byte is held, so later changes on `bus_din` do not move the address in use.
- R4: `bus_oe` is high only while the block is selected, `io_m` is low, `rd_n` is low and `wr_n` is high.
- R5: A read of an offset returns on `bus_dout` the byte last written to that offset. The offset is {addr_hi[1:0], latched low byte}.
- R6: A write commits on the rising edge of `wr_n`. It stores the data that `bus_din` held in the last clock in which `wr_n` was low, at the latched address.
- R7: If `rd_n` and `wr_n` are low together, no write takes place and `bus_oe` stays low.
- R8: Bits 3:0 and bits 7:4 of each byte are kept in separate nibble arrays. Both halves are stored and returned unchanged, including bytes whose nibbles differ, such as 0Fh and F0h.
- R9: After reset, `bus_oe` is low and the held low address byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe: shared lines carry the low address while high |
| addr_hi | input | 8 | Address bits 15:8 |
| bus_din | input | 8 | Shared address/data lines, inbound view |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| io_m | input | 1 | High for IO cycles, low for memory cycles |
| bus_dout | output | 8 | Shared lines, outbound data |
| bus_oe | output | 1 | High when the block drives the shared lines |

## Verification
A wrong select decode or a missed IO qualifier appears at once as `bus_oe` rising during an access that should be ignored. It can also show up later, as a read inside the window returning a byte overwritten by a stray write. A low-address latch that leaks shows up in the same read cycle: the bench changes `bus_din` after the strobe falls, so the wrong location is fetched. A lost nibble or a mis-timed commit shows up only at the next read of that offset, so the random mix re-reads each written offset many times.

// File: rtl/mux_bus_ram_pkg.sv
package mux_bus_ram_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = 10;
  localparam int SEL_W  = ADDR_W - OFS_W;
  localparam int DEPTH  = 1 << OFS_W;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/lo_addr_latch.sv
module lo_addr_latch
  import mux_bus_ram_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ale,
  input  byte_t bus_din,
  output byte_t lo_addr
);
  byte_t held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held_q <= '0;
    else if (ale) held_q <= bus_din;
  end

  // transparent while the strobe is high
  assign lo_addr = ale ? bus_din : held_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale)) |-> $stable(held_q)); // R3
endmodule

// File: rtl/sel_decode.sv
module sel_decode
  import mux_bus_ram_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_PATTERN = 6'b001000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] addr_hi,
  output logic              sel
);
  localparam int HI_SEL = BYTE_W - SEL_W;
  localparam int BASE   = int'(SEL_PATTERN) * DEPTH;

  assign sel = (addr_hi[BYTE_W-1:HI_SEL] == SEL_PATTERN);

  AST_SEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (int'({addr_hi, 8'h00}) >= BASE && int'({addr_hi, 8'h00}) < BASE + DEPTH)); // R1
endmodule

// File: rtl/nibble_array.sv
module nibble_array
  import mux_bus_ram_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  ofs_t             waddr,
  input  logic [NIB_W-1:0] wdata,
  input  ofs_t             raddr,
  output logic [NIB_W-1:0] rdata
);
  logic [NIB_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/mux_bus_ram.sv
module mux_bus_ram
  import mux_bus_ram_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_PATTERN = 6'b001000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [BYTE_W-1:0] addr_hi,
  input  logic [BYTE_W-1:0] bus_din,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              io_m,
  output logic [BYTE_W-1:0] bus_dout,
  output logic              bus_oe
);
  localparam int NIBS = BYTE_W / NIB_W;
  localparam int HI_OFS = OFS_W - BYTE_W;

  byte_t lo_addr;
  logic  sel;
  ofs_t  ofs;
  logic  wr_ok_q;
  ofs_t  wofs_q;
  byte_t wdat_q;
  logic  commit;

  lo_addr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale), .bus_din(bus_din), .lo_addr(lo_addr)
  );

  sel_decode #(.SEL_PATTERN(SEL_PATTERN)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .sel(sel)
  );

  assign ofs = {addr_hi[HI_OFS-1:0], lo_addr};

  // capture the write phase every clock the strobe is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ok_q <= 1'b0;
      wofs_q  <= '0;
      wdat_q  <= '0;
    end else begin
      wr_ok_q <= !wr_n && rd_n && !io_m && sel;
      if (!wr_n) begin
        wofs_q <= ofs;
        wdat_q <= bus_din;
      end
    end
  end

  // commit on the rising edge of the write strobe
  assign commit = wr_ok_q && wr_n;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    nibble_array u_arr (
      .clk(clk),
      .we(commit),
      .waddr(wofs_q),
      .wdata(wdat_q[g*NIB_W +: NIB_W]),
      .raddr(ofs),
      .rdata(bus_dout[g*NIB_W +: NIB_W])
    );
  end

  assign bus_oe = sel && !io_m && !rd_n && wr_n;

  AST_COMMIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(!wr_n) && wr_n)); // R6
  AST_COMMIT_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(!io_m && rd_n)); // R2
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!rd_n && wr_n && !io_m)); // R4
  AST_NO_CONFLICT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |=> !commit); // R7
endmodule

// File: tb/test_mux_bus_ram.sv
module test_mux_bus_ram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] addr_hi = '0;
  logic [7:0] bus_din = '0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       io_m = 1'b0;
  logic [7:0] bus_dout;
  logic       bus_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] mem [1024];
  bit         known [1024];

  always #10 clk = ~clk;

  mux_bus_ram i_mux_bus_ram (
    .clk(clk), .rst_n(rst_n), .ale(ale), .addr_hi(addr_hi), .bus_din(bus_din),
    .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  function automatic bit in_win(input logic [15:0] a);
    return a[15:10] == 6'b001000;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [15:0] a, input logic io);
    @(negedge clk);
    addr_hi = a[15:8]; bus_din = a[7:0]; io_m = io; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0; bus_din = 8'($urandom);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic io);
    addr_phase(a, io);
    @(negedge clk);
    bus_din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; bus_din = 8'($urandom);
    @(negedge clk);
    io_m = 1'b0;
    if (in_win(a) && !io) begin
      mem[a[9:0]] = d; known[a[9:0]] = 1'b1;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input logic io, input string req);
    addr_phase(a, io);
    @(negedge clk);
    rd_n = 1'b0; bus_din = 8'($urandom);
    #5;
    check({req, " oe"}, {7'd0, bus_oe}, {7'd0, in_win(a) && !io});
    if (in_win(a) && !io && known[a[9:0]]) check({req, " data"}, bus_dout, mem[a[9:0]]);
    @(negedge clk);
    rd_n = 1'b1; io_m = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 oe after reset", {7'd0, bus_oe}, 8'd0);
    rst_n = 1'b1;
    // R9: held low byte is 00h - read with ale never raised
    @(negedge clk);
    addr_hi = 8'h20; io_m = 1'b0;
    // write through held address 2000h without an address phase
    bus_din = 8'h5A; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    mem[0] = 8'h5A; known[0] = 1'b1;
    do_read(16'h2000, 1'b0, "R9 held low byte");
    // R8 nibble integrity
    do_write(16'h2010, 8'h0F, 1'b0);
    do_write(16'h2011, 8'hF0, 1'b0);
    do_write(16'h23FF, 8'hA5, 1'b0);
    do_read(16'h2010, 1'b0, "R8 0F");
    do_read(16'h2011, 1'b0, "R8 F0");
    do_read(16'h23FF, 1'b0, "R1 top edge");
    // R1 just outside window: no drive, no store
    do_write(16'h2410, 8'h33, 1'b0);
    do_write(16'h1C10, 8'h44, 1'b0);
    do_read(16'h2410, 1'b0, "R1 above window");
    do_read(16'h1FFF, 1'b0, "R1 below window");
    do_read(16'h2010, 1'b0, "R1 no alias store");
    // R2 IO cycles
    do_write(16'h2011, 8'h99, 1'b1);
    do_read(16'h2011, 1'b1, "R2 io read");
    do_read(16'h2011, 1'b0, "R2 io write ignored");
    // R7 conflict: both strobes low
    addr_phase(16'h2010, 1'b0);
    @(negedge clk);
    bus_din = 8'h77; wr_n = 1'b0; rd_n = 1'b0;
    #5;
    check("R7 oe during conflict", {7'd0, bus_oe}, 8'd0);
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    do_read(16'h2010, 1'b0, "R7 no write");
    // R4: read strobe high, selected -> no drive
    addr_phase(16'h2010, 1'b0);
    #5;
    check("R4 idle oe", {7'd0, bus_oe}, 8'd0);
    // R6: data from last low clock of a longer write strobe
    addr_phase(16'h2222, 1'b0);
    @(negedge clk); bus_din = 8'h11; wr_n = 1'b0;
    @(negedge clk); bus_din = 8'hC3;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    mem[10'h222] = 8'hC3; known[10'h222] = 1'b1;
    do_read(16'h2222, 1'b0, "R6 last data");
    // R3/R5 random mix (reads scramble bus_din after the strobe)
    for (int i = 0; i < 600; i++) begin
      a = 16'($urandom);
      if ($urandom % 4 != 0) a[15:10] = 6'b001000;
      if ($urandom % 2 == 0)
        do_write(a, 8'($urandom), ($urandom % 5) == 0);
      else
        do_read(a, ($urandom % 5) == 0, "R5 R3 random read");
    end
    for (int i = 0; i < 64; i++) do_read({6'b001000, 10'(i * 16)}, 1'b0, "R5 sweep");
    finish_run();
  end
endmodule